// File: doc/BRIEF.md
# Processor Clock Phase and Reset Sequencer

This block derives a two-phase processor clock from the system clock and steers the processor through reset. Each processor cycle lasts two system clocks: a phase 1 clock followed by a phase 2 clock. The block reports which phase comes next and flags each phase 2 clock. The first clock edge that samples the reset input high re-aligns this phase, so every system that starts from the same reset edge has the same phase.

While reset is held, the sequencer sets the external bus pins to fixed override values and releases the data bus. It measures how long reset stays high. On release it decides between two outcomes. A pulse of more than `MIN_RST_CYC` sampled clocks is a valid reinitialization: the block starts a countdown of `INIT_CYC` clocks and ends it with a one-clock start-fetch pulse. A shorter pulse is a glitch: the block raises a sticky short-reset flag and returns to the state it had before the pulse. A glitch neither reloads nor advances the countdown.

The controller has three states. HOLD covers reset asserted. COUNT is the initialization countdown. RUN is normal operation. The transitions are: any state to HOLD when reset is sampled high; HOLD to COUNT on a valid release; HOLD back to the saved state (COUNT or RUN) on a short release; COUNT to RUN when the countdown expires. The reset input is synchronous to `clk`.

Top module: `phase_reset_seq`

## Requirements
- R1: Outside a reset rising edge, `ph_tick` alternates on every clock. `ph_next2` is always its complement (1 = the next clock is phase 2). This also holds while reset is high and across the reset release, whichever phase the release falls in.
- R2: After the first edge that samples `rst_in` high following a low sample, the next clock is phase 2 (`ph_tick`=1, `ph_next2`=0).
- R3: Reset width is the number of consecutive edges that sample `rst_in` high. A width of 17 or more (more than `MIN_RST_CYC`=16) is a valid reset. A width of 16 or less is short.
- R4: In every clock after an edge that samples `rst_in` high, the outputs take their override values: `pin_force`=1, `addr_force` all ones, `data_float`=1, and `ctl_force`=8'h1F. The `ctl_force` bits are: bit0 status0, bit1 status1, bit2 coprocessor acknowledge, bit3 upper-byte enable, bit4 lock, each forced high; bit5 memory/IO, bit6 code/interrupt-acknowledge, bit7 hold acknowledge, each forced low. After an edge that samples `rst_in` low, all four outputs are 0 unless the previous state rule keeps HOLD.
- R5: Call the first low-sampling edge after a valid reset edge F. `start_fetch` is then high for exactly one clock, after edge F+`INIT_CYC` (default 50). No further pulse follows until the next valid reset.
- R6: A short reset sets `short_rst`, which stays set. The sequencer returns to its previous state. The countdown holds its value for the whole pulse, so a pending start is delayed by the pulse width plus one clock and is never restarted.
- R7: A valid reset release clears `short_rst` on edge F.
- R8: A valid reset that arrives during the countdown discards it. The next start pulse is timed only from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Synchronous active-high reset request |
| ph_next2 | output | 1 | High when the next clock is phase 2 |
| ph_tick | output | 1 | High during each phase 2 clock |
| pin_force | output | 1 | Bus pin overrides are active |
| addr_force | output | ADDR_W | Address override value |
| ctl_force | output | 8 | Control pin override values, layout in R4 |
| data_float | output | 1 | Data bus released to high impedance |
| start_fetch | output | 1 | One-clock pulse when initialization ends |
| short_rst | output | 1 | Sticky flag for a too-short reset |

## Verification
The phase outputs and all override outputs are due one clock after the edge that samples the reset level. The start pulse is due `INIT_CYC` edges after the release edge, and later by the width plus one for each short pulse taken during the countdown. The short flag changes on the release edge itself. A behavioural model in the bench advances on the same edge as the design. All outputs are compared at the falling edge, midway between updates, so every result is read in the clock it is due. Directed pulses of widths 16 and 17 pin down the boundary of R3.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_INIT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic hold_ack;
        logic code_inta;
        logic mem_io;
        logic lock;
        logic byte_hi;
        logic coproc_ack;
        logic stat1;
        logic stat0;
    } ctl_pins_t;

    function automatic ctl_pins_t ctl_reset_value();
        ctl_pins_t v;
        v.stat0      = 1'b1;
        v.stat1      = 1'b1;
        v.coproc_ack = 1'b1;
        v.byte_hi    = 1'b1;
        v.lock       = 1'b1;
        v.mem_io     = 1'b0;
        v.code_inta  = 1'b0;
        v.hold_ack   = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/phase_gen.sv
module phase_gen (
    input  logic clk,
    input  logic realign,
    output logic ph2_now
);
    logic ph2_q;

    always_ff @(posedge clk) begin
        if (realign) begin
            ph2_q <= 1'b1;
        end else begin
            ph2_q <= ~ph2_q;
        end
    end

    assign ph2_now = ph2_q;
endmodule

// File: rtl/rst_width_mon.sv
module rst_width_mon #(
    parameter int MIN_RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_rise,
    output logic rst_fall,
    output logic long_ok
);
    localparam int SAT = MIN_RST_CYC + 1;
    localparam int WW  = $clog2(SAT + 1);

    logic          rst_q;
    logic [WW-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        rst_q <= rst_in;
        if (rst_in) begin
            if (wcnt_q != WW'(SAT)) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end else begin
            wcnt_q <= '0;
        end
    end

    assign rst_rise = rst_in & ~rst_q;
    assign rst_fall = ~rst_in & rst_q;
    assign long_ok  = (wcnt_q > WW'(MIN_RST_CYC));
endmodule

// File: rtl/init_timer.sv
module init_timer #(
    parameter int INIT_CYC = 50,
    localparam int CW = $clog2(INIT_CYC + 1)
) (
    input  logic          clk,
    input  logic          load,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load) begin
            cnt_q <= CW'(INIT_CYC);
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/phase_reset_seq.sv
module phase_reset_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int INIT_CYC    = 50,
    parameter int MIN_RST_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_in,
    output logic              ph_next2,
    output logic              ph_tick,
    output logic              pin_force,
    output logic [ADDR_W-1:0] addr_force,
    output logic [7:0]        ctl_force,
    output logic              data_float,
    output logic              start_fetch,
    output logic              short_rst
);
    localparam int CW = $clog2(INIT_CYC + 1);

    seq_state_t    state_q, state_d, resume_q;
    logic          rst_rise, rst_fall, long_ok;
    logic          ph2_now;
    logic [CW-1:0] init_cnt;
    logic          init_last;
    logic          start_q, short_q;
    logic          cnt_load, cnt_step;

    rst_width_mon #(.MIN_RST_CYC(MIN_RST_CYC)) u_mon (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_rise(rst_rise),
        .rst_fall(rst_fall),
        .long_ok (long_ok)
    );

    phase_gen u_phase (
        .clk    (clk),
        .realign(rst_rise),
        .ph2_now(ph2_now)
    );

    assign cnt_load = rst_fall & long_ok;
    assign cnt_step = (state_q == ST_INIT) & ~rst_in;

    init_timer #(.INIT_CYC(INIT_CYC)) u_timer (
        .clk (clk),
        .load(cnt_load),
        .step(cnt_step),
        .cnt (init_cnt),
        .last(init_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_in) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = long_ok ? ST_INIT : resume_q;
                ST_INIT: state_d = init_last ? ST_RUN : ST_INIT;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_RUN;
            endcase
        end
    end

    // state register and per-state registered flags
    always_ff @(posedge clk) begin
        state_q <= state_d;
        if (rst_in && state_q != ST_HOLD) begin
            resume_q <= state_q;
        end
        start_q <= (state_q == ST_INIT) && init_last && !rst_in;
        if (state_q == ST_HOLD && !rst_in) begin
            short_q <= !long_ok;
        end
    end

    // output decode
    always_comb begin
        pin_force  = (state_q == ST_HOLD);
        addr_force = pin_force ? '1 : '0;
        ctl_force  = pin_force ? ctl_reset_value() : 8'h00;
        data_float = pin_force;
    end

    assign ph_tick     = ph2_now;
    assign ph_next2    = ~ph2_now;
    assign start_fetch = start_q;
    assign short_rst   = short_q;

    // checker liveness: becomes true after the first edge
    logic chk_live;
    always_ff @(posedge clk) chk_live <= 1'b1;

    p_tick_alternates_r1: assert property (@(posedge clk) disable iff (!chk_live || rst_in)
        ph_tick |=> !ph_tick);
    p_tick_returns_r1: assert property (@(posedge clk) disable iff (!chk_live || rst_in)
        !ph_tick |=> ph_tick);
    p_realign_r2: assert property (@(posedge clk) disable iff (!chk_live)
        (rst_in && !$past(rst_in)) |=> ph_tick);
    p_pins_track_r4: assert property (@(posedge clk) disable iff (!chk_live)
        $past(rst_in) |-> (pin_force && data_float && &addr_force));
    p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (!chk_live)
        start_fetch |=> !start_fetch);
    p_hold_freezes_count_r6: assert property (@(posedge clk) disable iff (!chk_live)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> $stable(init_cnt));
    p_no_start_in_hold_r6: assert property (@(posedge clk) disable iff (!chk_live)
        pin_force |-> !start_fetch);
endmodule

// File: tb/phase_reset_seq_bench.sv
module phase_reset_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int INIT_CYC   = 50;
    localparam int MIN_RST    = 16;

    logic              clk = 1'b0;
    logic              rst_in = 1'b0;
    logic              ph_next2, ph_tick, pin_force, data_float, start_fetch, short_rst;
    logic [ADDR_W-1:0] addr_force;
    logic [7:0]        ctl_force;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_reset_seq #(.ADDR_W(ADDR_W), .INIT_CYC(INIT_CYC), .MIN_RST_CYC(MIN_RST)) u_phase_reset_seq (
        .clk(clk), .rst_in(rst_in), .ph_next2(ph_next2), .ph_tick(ph_tick),
        .pin_force(pin_force), .addr_force(addr_force), .ctl_force(ctl_force),
        .data_float(data_float), .start_fetch(start_fetch), .short_rst(short_rst)
    );

    // behavioural reference: 0 = hold, 1 = counting, 2 = running
    int m_state = 2, m_resume = 2, m_cnt = 0, m_width = 0;
    bit m_rstq = 0, m_ph2 = 0, m_start = 0, m_short = 0, m_rose = 0;
    bit cmp_on = 0, short_on = 0;
    int seen_rise = 0;

    always @(posedge clk) begin
        bit rise, nstart;
        rise   = rst_in && !m_rstq;
        nstart = (m_state == 1) && (m_cnt == 1) && !rst_in;
        m_ph2  = rise ? 1'b1 : !m_ph2;
        if (rst_in) begin
            if (m_state != 0) m_resume = m_state;
            if (m_width <= MIN_RST) m_width++;
            m_state = 0;
        end else begin
            if (m_state == 0) begin
                if (m_width > MIN_RST) begin
                    m_state = 1; m_cnt = INIT_CYC; m_short = 0; short_on = 1;
                end else begin
                    m_state = m_resume; m_short = 1;
                end
            end else if (m_state == 1) begin
                if (m_cnt == 1) m_state = 2;
                else m_cnt--;
            end
            m_width = 0;
        end
        m_start = nstart;
        m_rstq  = rst_in;
        m_rose  = rise;
        if (rise) seen_rise++;
        if (seen_rise > 0 && !rise) cmp_on = 1;
    end

    task automatic check1(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check1(m_rose ? "R2" : "R1", "ph_tick", 32'(ph_tick), 32'(m_ph2));
            check1(m_rose ? "R2" : "R1", "ph_next2", 32'(ph_next2), 32'(!m_ph2));
            check1("R4", "pin_force", 32'(pin_force), 32'(m_state == 0));
            check1("R4", "data_float", 32'(data_float), 32'(m_state == 0));
            check1("R4", "ctl_force", 32'(ctl_force), (m_state == 0) ? 32'h1F : 32'h0);
            check1("R4", "addr_force", 32'(addr_force),
                   (m_state == 0) ? 32'((1 << ADDR_W) - 1) : 32'h0);
            if (seen_rise > 1 || m_state != 0)
                check1("R5", "start_fetch", 32'(start_fetch), 32'(m_start));
            if (short_on)
                check1(m_short ? "R6" : "R7", "short_rst", 32'(short_rst), 32'(m_short));
        end
    end

    task automatic pulse(int hi);
        rst_in = 1'b1;
        repeat (hi) @(negedge clk);
        rst_in = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    int starts = 0;
    always @(negedge clk) if (start_fetch) starts++;

    initial begin
        idle(3);
        pulse(20);                       // valid reset, R3 long side
        idle(60);                        // start pulse, R5
        check1("R5", "start count", 32'(starts), 32'd1);
        pulse(5);                        // short reset while running, R6
        idle(10);
        check1("R6", "short flag after glitch", 32'(short_rst), 32'd1);
        check1("R6", "no restart", 32'(starts), 32'd1);
        idle(1);
        pulse(21);                       // other alignment, R1 R2 R7
        idle(20);
        pulse(3);                        // glitch during countdown, R6
        idle(70);
        check1("R6", "delayed start", 32'(starts), 32'd2);
        pulse(16);                       // boundary: short
        idle(4);
        check1("R3", "width 16 short", 32'(short_rst), 32'd1);
        pulse(17);                       // boundary: valid
        idle(3);
        check1("R3", "width 17 valid", 32'(short_rst), 32'd0);
        idle(60);
        check1("R3", "start after 17", 32'(starts), 32'd3);
        pulse(30);
        idle(25);
        pulse(25);                       // valid reset mid-count, R8
        idle(30);
        check1("R8", "count discarded", 32'(starts), 32'd3);
        idle(40);
        check1("R8", "start from new release", 32'(starts), 32'd4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule